// File: doc/BRIEF.md
# Broadcast Transmit Controller with Private Backoff

This block schedules the transmission of frames that get no acknowledgment and no retry, such as beacons or buffered group-addressed traffic. Software places a packet buffer index, an antenna mask, a PHY mode, a forced-backoff flag and a slot count on the configuration inputs. It then raises the start input. If the medium has been idle for a DIFS interval and no backoff is forced, the frame goes out at once. Otherwise the block loads the slot count into a backoff counter of its own and counts it down before it transmits.

The backoff counter belongs to this controller alone. A beacon or group frame can therefore defer to medium activity without disturbing the backoff of the main data controller. Software can freeze the countdown with a pause input so that a higher-priority controller can use the PHY. The reported state shows whether the freeze has taken hold, which is the case when the state is IDLE or DEFER. The transmission ends on the PHY's done indication, and no response timeout follows it. A software reset returns the machine to IDLE from any state and clears the counter, which also cancels a pending beacon.

Top module: `bcast_tx_ctrl`

## Requirements
- R1: After the asynchronous reset, `state` is IDLE (0), `tx_start` is low and `bo_count` is 0. The state codes are IDLE=0, START_BO=1, DEFER=2, DO_TX=3, TX_WAIT=4.
- R2: A request is taken only on a rising edge of `start_en` seen while the state is IDLE. Holding `start_en` high never launches a second transmission, and a rising edge in any other state is ignored.
- R3: On a request with `medium_idle` high and `cfg_force_bo` low, the state is DO_TX and `tx_start` is high in the cycle after the clock edge that samples the request.
- R4: On a request with `medium_idle` low or `cfg_force_bo` high, the state passes through START_BO to DEFER, with `bo_count` equal to `cfg_slots`. With the medium idle throughout, `tx_start` rises on the 3+SLOT_CYC*N-th edge, counting the request edge as the first, where N is `cfg_slots`.
- R5: In DEFER the count drops by one after every SLOT_CYC consecutive cycles with `medium_idle` high. A cycle with the medium busy holds the count and restarts the partial slot.
- R6: While `pause_bo` is high in DEFER, the count and the partial slot are frozen and the state stays DEFER, even when the count is 0. The first edge after the release resumes the countdown where it stopped.
- R7: `tx_start` is a single-cycle pulse. `tx_buf`, `tx_ant` and `tx_mode` carry the values captured at the request, and later changes to the configuration inputs do not alter them. `tx_mode` passes the value through unchanged: 1 means non-HT and 2 means HT mixed format.
- R8: After DO_TX the state is TX_WAIT until `phy_tx_done` is seen, and then IDLE. No further wait follows.
- R9: `sw_reset` puts the state in IDLE and clears `bo_count` on the next edge, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_reset | input | 1 | Software reset to IDLE, clears backoff |
| start_en | input | 1 | Start bit; its rising edge requests a transmission |
| cfg_buf | input | BUF_W | Packet buffer index |
| cfg_ant | input | ANT_W | Antenna mask |
| cfg_mode | input | MODE_W | PHY mode (1 non-HT, 2 HT mixed) |
| cfg_force_bo | input | 1 | Always back off before transmitting |
| cfg_slots | input | SLOT_W | Backoff slot count |
| medium_idle | input | 1 | Medium idle for at least DIFS |
| pause_bo | input | 1 | Freeze the backoff countdown |
| phy_tx_done | input | 1 | PHY has finished the transmission |
| tx_start | output | 1 | One-cycle request to the PHY |
| tx_buf | output | BUF_W | Buffer index captured at request |
| tx_ant | output | ANT_W | Antenna mask captured at request |
| tx_mode | output | MODE_W | PHY mode captured at request |
| state | output | 3 | Current state code |
| bo_count | output | SLOT_W | Remaining backoff slots |

## Verification
The hardest case to reach from the ports is a partial slot that is interrupted. The slot timer has to be part-way through a slot when the medium goes busy or the pause rises, and the exact launch edge then shows whether the partial slot was restarted or kept. The stimulus gets there with directed sequences. It holds the medium idle for a few edges less than a slot and then drops it. In a second sequence it raises the pause in the middle of a countdown, and in a third it raises the pause before a zero-slot request, so that DEFER is held at a count of zero. Random transactions with random slot counts, flags and parameters then check the launch edge and the captured fields.

// File: rtl/bcast_tx_pkg.sv
package bcast_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_START_BO = 3'd1,
    ST_DEFER    = 3'd2,
    ST_DO_TX    = 3'd3,
    ST_TX_WAIT  = 3'd4
  } bc_state_e;
endpackage

// File: rtl/bcast_edge_det.sv
module bcast_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/bcast_backoff.sv
module bcast_backoff #(
  parameter int SLOT_W   = 8,
  parameter int SLOT_CYC = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [SLOT_W-1:0] load_val,
  input  logic              run,
  input  logic              hold,
  output logic [SLOT_W-1:0] count,
  output logic              zero
);
  localparam int TMR_W = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(SLOT_CYC - 1);

  logic [SLOT_W-1:0] cnt_q, cnt_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic              slot_end;

  assign slot_end = (tmr_q == TMR_LAST);

  always_comb begin
    cnt_d = cnt_q;
    tmr_d = tmr_q;
    if (clr) begin
      cnt_d = '0;
      tmr_d = '0;
    end else if (load) begin
      cnt_d = load_val;
      tmr_d = '0;
    end else if (run) begin
      if (slot_end) begin
        tmr_d = '0;
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      end else begin
        tmr_d = tmr_q + 1'b1;
      end
    end else if (!hold) begin
      tmr_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tmr_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      tmr_q <= tmr_d;
    end
  end

  assign count = cnt_q;
  assign zero  = (cnt_q == '0);
endmodule

// File: rtl/bcast_fsm.sv
module bcast_fsm
  import bcast_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sw_reset,
  input  logic      start_pulse,
  input  logic      medium_idle,
  input  logic      force_bo,
  input  logic      pause,
  input  logic      bo_zero,
  input  logic      phy_tx_done,
  output bc_state_e st,
  output logic      bo_clr,
  output logic      bo_load,
  output logic      bo_run,
  output logic      bo_hold,
  output logic      cfg_latch
);
  bc_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:
        if (start_pulse) begin
          if (medium_idle && !force_bo) st_d = ST_DO_TX;
          else                          st_d = ST_START_BO;
        end
      ST_START_BO: st_d = ST_DEFER;
      ST_DEFER:
        if (!pause && bo_zero) st_d = ST_DO_TX;
      ST_DO_TX:    st_d = ST_TX_WAIT;
      ST_TX_WAIT:
        if (phy_tx_done) st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
    if (sw_reset) st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign st        = st_q;
  assign bo_clr    = sw_reset;
  assign bo_load   = (st_q == ST_START_BO) && !sw_reset;
  assign bo_run    = (st_q == ST_DEFER) && medium_idle && !pause && !sw_reset;
  assign bo_hold   = pause;
  assign cfg_latch = (st_q == ST_IDLE) && start_pulse && !sw_reset;
endmodule

// File: rtl/bcast_tx_ctrl.sv
module bcast_tx_ctrl
  import bcast_tx_pkg::*;
#(
  parameter int BUF_W    = 4,
  parameter int ANT_W    = 4,
  parameter int MODE_W   = 2,
  parameter int SLOT_W   = 8,
  parameter int SLOT_CYC = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_reset,
  input  logic              start_en,
  input  logic [BUF_W-1:0]  cfg_buf,
  input  logic [ANT_W-1:0]  cfg_ant,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              cfg_force_bo,
  input  logic [SLOT_W-1:0] cfg_slots,
  input  logic              medium_idle,
  input  logic              pause_bo,
  input  logic              phy_tx_done,
  output logic              tx_start,
  output logic [BUF_W-1:0]  tx_buf,
  output logic [ANT_W-1:0]  tx_ant,
  output logic [MODE_W-1:0] tx_mode,
  output logic [2:0]        state,
  output logic [SLOT_W-1:0] bo_count
);
  logic      start_pulse;
  logic      bo_clr, bo_load, bo_run, bo_hold, bo_zero, cfg_latch;
  bc_state_e st;

  logic [BUF_W-1:0]  buf_q;
  logic [ANT_W-1:0]  ant_q;
  logic [MODE_W-1:0] mode_q;

  bcast_edge_det u_start (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (start_en),
    .rise  (start_pulse)
  );

  bcast_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_reset    (sw_reset),
    .start_pulse (start_pulse),
    .medium_idle (medium_idle),
    .force_bo    (cfg_force_bo),
    .pause       (pause_bo),
    .bo_zero     (bo_zero),
    .phy_tx_done (phy_tx_done),
    .st          (st),
    .bo_clr      (bo_clr),
    .bo_load     (bo_load),
    .bo_run      (bo_run),
    .bo_hold     (bo_hold),
    .cfg_latch   (cfg_latch)
  );

  bcast_backoff #(
    .SLOT_W   (SLOT_W),
    .SLOT_CYC (SLOT_CYC)
  ) u_bo (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (bo_clr),
    .load     (bo_load),
    .load_val (cfg_slots),
    .run      (bo_run),
    .hold     (bo_hold),
    .count    (bo_count),
    .zero     (bo_zero)
  );

  // Transmit parameters captured at the accepted request (clock enable).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      ant_q  <= '0;
      mode_q <= '0;
    end else if (cfg_latch) begin
      buf_q  <= cfg_buf;
      ant_q  <= cfg_ant;
      mode_q <= cfg_mode;
    end
  end

  assign tx_start = (st == ST_DO_TX);
  assign tx_buf   = buf_q;
  assign tx_ant   = ant_q;
  assign tx_mode  = mode_q;
  assign state    = st;
endmodule

// File: rtl/bcast_tx_ctrl_chk.sv
module bcast_tx_ctrl_chk #(
  parameter int SLOT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_reset,
  input logic              start_en,
  input logic              cfg_force_bo,
  input logic              medium_idle,
  input logic              pause_bo,
  input logic              phy_tx_done,
  input logic              tx_start,
  input logic [2:0]        state,
  input logic [SLOT_W-1:0] bo_count
);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 && !start_en) |=> (state == 3'd0));

  p_immediate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 && $rose(start_en) && medium_idle && !cfg_force_bo && !sw_reset)
    |=> (state == 3'd3));

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd2 && !sw_reset) |=>
    (bo_count == $past(bo_count) || bo_count == $past(bo_count) - 1'b1));

  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd2 && !medium_idle && !sw_reset) |=> $stable(bo_count));

  p_pause_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd2 && pause_bo && !sw_reset) |=> (state == 3'd2 && $stable(bo_count)));

  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  p_tx_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4 && !phy_tx_done && !sw_reset) |=> (state == 3'd4));

  p_sw_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> (state == 3'd0 && bo_count == '0));
endmodule

bind bcast_tx_ctrl bcast_tx_ctrl_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sw_reset     (sw_reset),
  .start_en     (start_en),
  .cfg_force_bo (cfg_force_bo),
  .medium_idle  (medium_idle),
  .pause_bo     (pause_bo),
  .phy_tx_done  (phy_tx_done),
  .tx_start     (tx_start),
  .state        (state),
  .bo_count     (bo_count)
);

// File: tb/bcast_tx_ctrl_test.sv
`timescale 1ns/1ps
module bcast_tx_ctrl_test;
  localparam int BUF_W = 4, ANT_W = 4, MODE_W = 2, SLOT_W = 8, SLOT = 9;

  logic clk = 1'b0;
  logic rst_n, sw_reset, start_en, cfg_force_bo, medium_idle, pause_bo, phy_tx_done;
  logic [BUF_W-1:0]  cfg_buf;
  logic [ANT_W-1:0]  cfg_ant;
  logic [MODE_W-1:0] cfg_mode;
  logic [SLOT_W-1:0] cfg_slots;
  logic              tx_start;
  logic [BUF_W-1:0]  tx_buf;
  logic [ANT_W-1:0]  tx_ant;
  logic [MODE_W-1:0] tx_mode;
  logic [2:0]        state;
  logic [SLOT_W-1:0] bo_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bcast_tx_ctrl #(.BUF_W(BUF_W), .ANT_W(ANT_W), .MODE_W(MODE_W),
                  .SLOT_W(SLOT_W), .SLOT_CYC(SLOT)) uut (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .start_en(start_en),
    .cfg_buf(cfg_buf), .cfg_ant(cfg_ant), .cfg_mode(cfg_mode),
    .cfg_force_bo(cfg_force_bo), .cfg_slots(cfg_slots),
    .medium_idle(medium_idle), .pause_bo(pause_bo), .phy_tx_done(phy_tx_done),
    .tx_start(tx_start), .tx_buf(tx_buf), .tx_ant(tx_ant), .tx_mode(tx_mode),
    .state(state), .bo_count(bo_count));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_latency(input bit force_bo, input bit idle, input int n);
    if (idle && !force_bo) return 1;
    return 3 + SLOT * n;
  endfunction

  // Count edges from request until tx_start is seen.
  task automatic wait_tx(output int n, output int st2, output int c2);
    n = 0; st2 = -1; c2 = -1;
    do begin
      step();
      n++;
      if (n == 2) begin st2 = int'(state); c2 = int'(bo_count); end
    end while (!tx_start && n < 3000);
  endtask

  task automatic finish_tx(input string tag);
    step();
    chk({tag, " R7 pulse"}, int'(tx_start), 0);
    chk({tag, " R8 wait"}, int'(state), 4);
    step();
    chk({tag, " R8 still waiting"}, int'(state), 4);
    phy_tx_done = 1'b1;
    step();
    phy_tx_done = 1'b0;
    chk({tag, " R8 idle after done"}, int'(state), 0);
  endtask

  task automatic run_tx(input bit force_bo, input int n, input int b, input int a, input int m);
    int lat, st2, c2;
    cfg_force_bo = force_bo; cfg_slots = SLOT_W'(n);
    cfg_buf = BUF_W'(b); cfg_ant = ANT_W'(a); cfg_mode = MODE_W'(m);
    start_en = 1'b1;
    wait_tx(lat, st2, c2);
    chk("R3/R4 launch edge", lat, exp_latency(force_bo, 1'b1, n));
    if (force_bo) begin
      chk("R4 DEFER reached", st2, 2);
      chk("R4 count loaded", c2, n);
    end
    cfg_buf = ~cfg_buf; cfg_ant = ~cfg_ant; cfg_mode = 2'd3;
    chk("R7 buf", int'(tx_buf), b);
    chk("R7 ant", int'(tx_ant), a);
    chk("R7 mode", int'(tx_mode), m);
    finish_tx("rand");
    repeat (3) step();
    chk("R2 held start no retrigger", int'(state), 0);
    start_en = 1'b0;
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat, st2, c2;
    void'($urandom(32'd2024));
    rst_n = 1'b0; sw_reset = 1'b0; start_en = 1'b0; cfg_force_bo = 1'b0;
    medium_idle = 1'b1; pause_bo = 1'b0; phy_tx_done = 1'b0;
    cfg_buf = '0; cfg_ant = '0; cfg_mode = '0; cfg_slots = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R1 state", int'(state), 0);
    chk("R1 tx_start", int'(tx_start), 0);
    chk("R1 bo_count", int'(bo_count), 0);

    // Immediate path, non-HT mode
    run_tx(1'b0, 5, 9, 3, 1);
    // Forced backoff, HT mixed mode
    run_tx(1'b1, 3, 6, 12, 2);
    run_tx(1'b1, 0, 1, 1, 1);

    // R5: busy medium forces backoff, partial slot restarts
    medium_idle = 1'b0; cfg_force_bo = 1'b0; cfg_slots = 8'd2;
    cfg_buf = 4'd5; cfg_ant = 4'd7; cfg_mode = 2'd1;
    start_en = 1'b1;
    repeat (40) step();
    chk("R4 busy start -> DEFER", int'(state), 2);
    chk("R5 busy holds count", int'(bo_count), 2);
    medium_idle = 1'b1;
    repeat (5) step();
    medium_idle = 1'b0;
    repeat (10) step();
    chk("R5 count after partial slot", int'(bo_count), 2);
    medium_idle = 1'b1;
    lat = 0;
    do begin step(); lat++; end while (!tx_start && lat < 3000);
    chk("R5 partial slot restarted", lat, 1 + SLOT * 2);
    finish_tx("busy");
    start_en = 1'b0; step();

    // R6: pause mid-countdown
    cfg_force_bo = 1'b1; cfg_slots = 8'd2; start_en = 1'b1;
    step(); step();
    repeat (4) step();
    pause_bo = 1'b1;
    repeat (20) step();
    chk("R6 paused state", int'(state), 2);
    chk("R6 paused count", int'(bo_count), 2);
    pause_bo = 1'b0;
    lat = 0;
    do begin step(); lat++; end while (!tx_start && lat < 3000);
    chk("R6 resume keeps partial slot", lat, 1 + SLOT * 2 - 4);
    finish_tx("pause");
    start_en = 1'b0; step();

    // R6: pause holds DEFER at zero count
    pause_bo = 1'b1; cfg_slots = 8'd0; start_en = 1'b1;
    repeat (10) step();
    chk("R6 zero count held in DEFER", int'(state), 2);
    pause_bo = 1'b0;
    step();
    chk("R6 release at zero launches", int'(tx_start), 1);
    // R2: rising edge during TX_WAIT ignored
    start_en = 1'b0; step();
    chk("R8 in TX_WAIT", int'(state), 4);
    start_en = 1'b1; step();
    phy_tx_done = 1'b1; step(); phy_tx_done = 1'b0;
    repeat (5) step();
    chk("R2 start in TX_WAIT ignored", int'(state), 0);
    start_en = 1'b0; step();

    // R9: software reset in DEFER and in TX_WAIT
    cfg_slots = 8'd5; start_en = 1'b1;
    repeat (4) step();
    sw_reset = 1'b1; step(); sw_reset = 1'b0;
    chk("R9 reset in DEFER -> IDLE", int'(state), 0);
    chk("R9 reset clears count", int'(bo_count), 0);
    repeat (20) step();
    chk("R2 held start after reset", int'(state), 0);
    start_en = 1'b0; step();
    cfg_force_bo = 1'b0; start_en = 1'b1;
    step(); step();
    chk("R8 TX_WAIT before reset", int'(state), 4);
    sw_reset = 1'b1; step(); sw_reset = 1'b0;
    chk("R9 reset in TX_WAIT -> IDLE", int'(state), 0);
    start_en = 1'b0; step();

    // Random transactions
    for (int i = 0; i < 40; i++) begin
      run_tx(1'($urandom_range(0, 1)), int'($urandom_range(0, 6)),
             int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
             int'($urandom_range(1, 2)));
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule